// File: doc/BRIEF.md
# Time-Multiplexed Servo Pulse Generator

This block drives up to eight hobby-servo control lines from a single frame timer and a single reusable width timer. A frame timer built from a clock prescaler and a terminal count emits a heartbeat strobe. On each heartbeat the block raises the output of the channel whose turn it is and starts a one-shot countdown loaded with that channel's width. When the countdown runs out, the output drops and an expiry strobe fires. The next heartbeat passes to the next channel in the rotation. Each servo therefore sees a frame rate equal to the heartbeat rate divided by the number of slots in the rotation.

Software, or a neighbouring register block, loads each channel's 16-bit width as two byte writes. The low byte is staged and the high byte commits the full value, so a heartbeat between the two writes never sees a half-written width. Widths are clamped at load time to the legal 1 ms to 2 ms window. With the defaults (24 MHz clock, width tick of clock/8) that window is 3000 to 6000 ticks, and the reset width of 0x1194 ticks gives 1.5 ms. A channel with its enable cleared keeps its line low but still uses up its slot, so the frame rate of the other channels stays the same. For a 30 Hz to 360 Hz frame per servo, the prescale and terminal count are set to clock / (frame rate × slots).

Top module: `servo_mux_top`

## Requirements
- R1: After reset all servo lines, `heartbeat` and `expire` are low, and the first heartbeat serves channel 0.
- R2: `heartbeat` pulses for one cycle every max(prescale,1) × (term_count + 1) clock cycles.
- R3: A heartbeat on an enabled channel raises that channel's line in the next cycle and holds it high for exactly W × TICK_DIV cycles, where W is the clamped width.
- R4: When the width countdown ends, the line falls and `expire` is high for one cycle in that same cycle. No further expiry occurs until a later heartbeat starts a new pulse.
- R5: The slot index advances by one per heartbeat and wraps to 0 after slot_count − 1. A slot_count of 0 or above NUM_CH means NUM_CH slots.
- R6: A write with `wr_hi`=0 only stages bits 7:0 for channel `wr_ch`. A write with `wr_hi`=1 sets the channel's width to {wr_data, staged byte}. A staged low byte on its own leaves the pulse width unchanged.
- R7: A width below MIN_TICKS is used as MIN_TICKS, and a width above MAX_TICKS is used as MAX_TICKS.
- R8: A channel whose `ch_enable` bit is 0 when its slot arrives produces no pulse and no expiry, but its slot still takes one heartbeat period.
- R9: At most one servo line is high at any time. A heartbeat that arrives while a pulse is still running ends that pulse in the same cycle the new slot starts.
- R10: After reset every channel's width is RST_TICKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prescale | input | DIV_W | Frame prescaler divide value (0 acts as 1) |
| term_count | input | TC_W | Frame terminal count; period is prescale × (term_count+1) |
| slot_count | input | SLOT_W | Number of slots in the rotation (0 means NUM_CH) |
| ch_enable | input | NUM_CH | Per-channel output enable |
| wr_en | input | 1 | Width byte write strobe |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_hi | input | 1 | 0: stage low byte, 1: write high byte and commit |
| wr_data | input | 8 | Write byte |
| servo_out | output | NUM_CH | Servo pulse lines |
| heartbeat | output | 1 | One-cycle frame strobe |
| expire | output | 1 | One-cycle width-timer expiry strobe |

## Verification
The bench sets the heartbeat period shorter than the pulse width. This checks that a late pulse is cut off at the next slot and never overlaps it. A design without the restart would show two lines high at once or an expiry inside the next slot. It writes only a low byte and checks that the pulse width stays the same. A design that copies bytes straight into the live width would change the pulse length too early. It also drives a disabled channel inside a rotation and checks that the slot gap stays in place and that no expiry appears for it. Widths below and above the legal window, a prescale of zero and a slot count of zero cover the edge encodings. A wrong clamp or wrong wrap logic gives pulse lengths or rotation orders that differ from the computed ones.

// File: rtl/servo_mux_pkg.sv
// Package: shared width type and the width clamp used by the width bank.
// Assumes 16-bit widths written as two 8-bit halves.
package servo_mux_pkg;
    parameter int unsigned W_BITS = 16;
    parameter int unsigned BYTE_W = 8;
    typedef logic [W_BITS-1:0] width_t;

    // Limit a requested width to the legal [lo, hi] window.
    function automatic width_t clamp_width(input width_t w, input width_t lo, input width_t hi);
        if (w < lo)
            return lo;
        else if (w > hi)
            return hi;
        else
            return w;
    endfunction
endpackage

// File: rtl/servo_mux_heartbeat.sv
// Frame timer: a prescaler feeding a terminal counter, emitting a
// one-cycle strobe every max(prescale,1)*(term_count+1) clocks.
// Assumes: config may change at any time; counters past a new limit wrap.
module servo_mux_heartbeat #(
    parameter int DIV_W = 8,
    parameter int TC_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] prescale,
    input  logic [TC_W-1:0]  term_count,
    output logic             hb_pulse
);
    logic [DIV_W-1:0] pre_q;
    logic [TC_W-1:0]  tc_q;
    logic [DIV_W-1:0] div_last;

    // Last prescaler value; a zero divide is treated as divide-by-one.
    always_comb begin
        div_last = (prescale == '0) ? '0 : prescale - DIV_W'(1);
    end

    // Advance prescaler and terminal counter, strobe on terminal wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q    <= '0;
            tc_q     <= '0;
            hb_pulse <= 1'b0;
        end else begin
            hb_pulse <= 1'b0;
            if (pre_q >= div_last) begin
                pre_q <= '0;
                if (tc_q >= term_count) begin
                    tc_q     <= '0;
                    hb_pulse <= 1'b1;
                end else begin
                    tc_q <= tc_q + TC_W'(1);
                end
            end else begin
                pre_q <= pre_q + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/servo_mux_width_bank.sv
// Per-channel width storage. A low-byte write is staged; a high-byte
// write commits both halves at once. The selected channel's width is
// presented clamped to [MIN_TICKS, MAX_TICKS].
// Assumes MIN_TICKS >= 1 so a loaded width is never zero.
module servo_mux_width_bank
    import servo_mux_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int CH_W      = 3,
    parameter int MIN_TICKS = 3000,
    parameter int MAX_TICKS = 6000,
    parameter int RST_TICKS = 4500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    output width_t            rd_width
);
    localparam width_t MIN_W = width_t'(MIN_TICKS);
    localparam width_t MAX_W = width_t'(MAX_TICKS);
    localparam width_t RST_W = width_t'(RST_TICKS);

    width_t width_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [BYTE_W-1:0] stage_q;

        // Stage the low byte, commit the full width on the high byte.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q    <= RST_W[BYTE_W-1:0];
                width_q[g] <= RST_W;
            end else if (wr_en && wr_ch == CH_W'(g)) begin
                if (wr_hi)
                    width_q[g] <= {wr_data, stage_q};
                else
                    stage_q <= wr_data;
            end
        end
    end

    // Clamped width of the channel about to be served.
    always_comb begin
        rd_width = clamp_width(width_q[rd_ch], MIN_W, MAX_W);
    end
endmodule

// File: rtl/servo_mux_pulse_timer.sv
// Shared one-shot width timer. A start loads the width and the channel;
// the timer counts width ticks of TICK_DIV clocks and, on the last tick,
// drops the line and strobes expiry. A new start always overrides a
// running pulse. Assumes TICK_DIV >= 2 and a nonzero load width.
module servo_mux_pulse_timer
    import servo_mux_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int CH_W     = 3,
    parameter int TICK_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CH_W-1:0]   start_ch,
    input  logic              start_en,
    input  width_t            load_width,
    output logic [NUM_CH-1:0] servo_out,
    output logic              expire
);
    localparam int SUB_W = $clog2(TICK_DIV);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICK_DIV - 1);

    logic             running_q;
    width_t           remain_q;
    logic [SUB_W-1:0] sub_q;
    logic [CH_W-1:0]  act_ch_q;

    // Load on start, otherwise count ticks down and stop on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            remain_q  <= '0;
            sub_q     <= '0;
            act_ch_q  <= '0;
            expire    <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (start) begin
                running_q <= start_en;
                remain_q  <= load_width;
                sub_q     <= '0;
                act_ch_q  <= start_ch;
            end else if (running_q) begin
                if (sub_q == SUB_LAST) begin
                    sub_q <= '0;
                    if (remain_q <= width_t'(1)) begin
                        running_q <= 1'b0;
                        expire    <= 1'b1;
                    end else begin
                        remain_q <= remain_q - width_t'(1);
                    end
                end else begin
                    sub_q <= sub_q + SUB_W'(1);
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
        // Only the channel owning the running pulse is driven high.
        assign servo_out[g] = running_q && (act_ch_q == CH_W'(g));
    end
endmodule

// File: rtl/servo_mux_top.sv
// Time-multiplexed servo pulse generator: one frame timer and one width
// timer serve NUM_CH outputs in rotation. Assumes NUM_CH >= 2.
module servo_mux_top
    import servo_mux_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int DIV_W     = 8,
    parameter int TC_W      = 16,
    parameter int TICK_DIV  = 8,
    parameter int MIN_TICKS = 3000,
    parameter int MAX_TICKS = 6000,
    parameter int RST_TICKS = 16'h1194,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int SLOT_W   = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  prescale,
    input  logic [TC_W-1:0]   term_count,
    input  logic [SLOT_W-1:0] slot_count,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic              wr_hi,
    input  logic [7:0]        wr_data,
    output logic [NUM_CH-1:0] servo_out,
    output logic              heartbeat,
    output logic              expire
);
    logic              hb_pulse;
    logic [CH_W-1:0]   sel_q;
    logic [SLOT_W-1:0] slots_eff;
    logic [SLOT_W-1:0] sel_inc;
    logic              hb_en;
    width_t            sel_width;

    servo_mux_heartbeat #(
        .DIV_W (DIV_W),
        .TC_W  (TC_W)
    ) u_heartbeat (
        .clk        (clk),
        .rst_n      (rst_n),
        .prescale   (prescale),
        .term_count (term_count),
        .hb_pulse   (hb_pulse)
    );

    servo_mux_width_bank #(
        .NUM_CH    (NUM_CH),
        .CH_W      (CH_W),
        .MIN_TICKS (MIN_TICKS),
        .MAX_TICKS (MAX_TICKS),
        .RST_TICKS (RST_TICKS)
    ) u_width_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_hi    (wr_hi),
        .wr_data  (wr_data),
        .rd_ch    (sel_q),
        .rd_width (sel_width)
    );

    servo_mux_pulse_timer #(
        .NUM_CH   (NUM_CH),
        .CH_W     (CH_W),
        .TICK_DIV (TICK_DIV)
    ) u_pulse_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (hb_pulse),
        .start_ch   (sel_q),
        .start_en   (hb_en),
        .load_width (sel_width),
        .servo_out  (servo_out),
        .expire     (expire)
    );

    // Effective rotation length and the next slot index.
    always_comb begin
        slots_eff = (slot_count == '0 || slot_count > SLOT_W'(NUM_CH))
                    ? SLOT_W'(NUM_CH) : slot_count;
        sel_inc   = SLOT_W'(sel_q) + SLOT_W'(1);
        hb_en     = ch_enable[sel_q];
    end

    // Step the slot index on every heartbeat, wrapping at the slot count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (hb_pulse)
            sel_q <= (sel_inc >= slots_eff) ? '0 : CH_W'(sel_inc);
    end

    assign heartbeat = hb_pulse;
endmodule

// File: rtl/servo_mux_checker.sv
// Property checker for servo_mux_top, attached with bind below.
module servo_mux_checker
    import servo_mux_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int CH_W      = 3,
    parameter int SLOT_W    = 4,
    parameter int MIN_TICKS = 3000,
    parameter int MAX_TICKS = 6000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] servo_out,
    input logic              heartbeat,
    input logic              expire,
    input logic              start_en,
    input width_t            load_width,
    input logic [CH_W-1:0]   sel,
    input logic [SLOT_W-1:0] slots_eff
);
    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(servo_out) <= 1); // R9

    AST_HB_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        heartbeat && start_en |=> $countones(servo_out) == 1); // R3

    AST_HB_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        heartbeat && !start_en |=> servo_out == '0); // R8

    AST_EXPIRE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> servo_out == '0); // R4

    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire); // R4

    AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        heartbeat |-> (load_width >= width_t'(MIN_TICKS) && load_width <= width_t'(MAX_TICKS))); // R7

    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        SLOT_W'(sel) < slots_eff); // R5
endmodule

bind servo_mux_top servo_mux_checker #(
    .NUM_CH    (NUM_CH),
    .CH_W      (CH_W),
    .SLOT_W    (SLOT_W),
    .MIN_TICKS (MIN_TICKS),
    .MAX_TICKS (MAX_TICKS)
) u_servo_mux_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .servo_out  (servo_out),
    .heartbeat  (heartbeat),
    .expire     (expire),
    .start_en   (hb_en),
    .load_width (sel_width),
    .sel        (sel_q),
    .slots_eff  (slots_eff)
);

// File: tb/servo_mux_top_bench.sv
module servo_mux_top_bench;
    localparam int NCH = 8;
    localparam int TDIV = 2;
    localparam int WMIN = 10;
    localparam int WMAX = 40;
    localparam int WRST = 25;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [7:0]     prescale = 8'd2;
    logic [15:0]    term_count = 16'd49;
    logic [3:0]     slot_count = 4'd8;
    logic [NCH-1:0] ch_enable = '1;
    logic           wr_en = 1'b0;
    logic [2:0]     wr_ch = '0;
    logic           wr_hi = 1'b0;
    logic [7:0]     wr_data = '0;
    logic [NCH-1:0] servo_out;
    logic           heartbeat;
    logic           expire;

    servo_mux_top #(
        .NUM_CH    (NCH),
        .TICK_DIV  (TDIV),
        .MIN_TICKS (WMIN),
        .MAX_TICKS (WMAX),
        .RST_TICKS (WRST)
    ) u_servo_mux_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .prescale   (prescale),
        .term_count (term_count),
        .slot_count (slot_count),
        .ch_enable  (ch_enable),
        .wr_en      (wr_en),
        .wr_ch      (wr_ch),
        .wr_hi      (wr_hi),
        .wr_data    (wr_data),
        .servo_out  (servo_out),
        .heartbeat  (heartbeat),
        .expire     (expire)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    // Monitor state, sampled on the falling edge.
    int hi_len [NCH];
    int last_len [NCH];
    int pulse_cnt [NCH];
    int seq [64];
    int seq_cyc [64];
    int seq_n = 0;
    int exp_cnt = 0;
    int exp_bad = 0;
    int fall_bad = 0;
    int multi_hot = 0;
    int hb_cnt = 0;
    int hb_gap = 0;
    int last_hb = 0;
    logic [NCH-1:0] prev_out = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if ($countones(servo_out) > 1) multi_hot++;
        if (expire) begin
            exp_cnt++;
            if (servo_out != '0) exp_bad++;
        end
        for (int c = 0; c < NCH; c++) begin
            if (servo_out[c]) begin
                hi_len[c]++;
                if (!prev_out[c] && seq_n < 64) begin
                    seq[seq_n] = c;
                    seq_cyc[seq_n] = cyc;
                    seq_n++;
                end
            end else if (prev_out[c]) begin
                last_len[c] = hi_len[c];
                hi_len[c] = 0;
                pulse_cnt[c]++;
                // A fall with no new line rising must be an expiry (R4)
                if (servo_out == '0 && !expire) fall_bad++;
            end
        end
        if (heartbeat) begin
            if (hb_cnt > 0) hb_gap = cyc - last_hb;
            last_hb = cyc;
            hb_cnt++;
        end
        prev_out = servo_out;
    end

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic clear_mon();
        for (int c = 0; c < NCH; c++) begin
            hi_len[c] = 0;
            last_len[c] = 0;
            pulse_cnt[c] = 0;
        end
        seq_n = 0;
        exp_cnt = 0;
        exp_bad = 0;
        fall_bad = 0;
        hb_cnt = 0;
        hb_gap = 0;
        prev_out = '0;
    endtask

    task automatic do_reset(input int pre, input int tc, input int slots, input logic [NCH-1:0] en);
        @(negedge clk);
        rst_n = 1'b0;
        prescale = 8'(pre);
        term_count = 16'(tc);
        slot_count = 4'(slots);
        ch_enable = en;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        clear_mon();
        rst_n = 1'b1;
    endtask

    task automatic wr_byte(input int ch, input logic hi, input int data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_ch = 3'(ch);
        wr_hi = hi;
        wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_width(input int ch, input int w);
        wr_byte(ch, 1'b0, w & 8'hFF);
        wr_byte(ch, 1'b1, (w >> 8) & 8'hFF);
    endtask

    // Wait for n heartbeats then a further settle time in clocks.
    task automatic wait_hb(input int n, input int settle);
        while (hb_cnt < n) @(posedge clk);
        repeat (settle) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(2, 49, 8, '1);
        @(negedge clk);
        chk("R1 servo_out after reset", int'(servo_out), 0);
        chk("R1 heartbeat after reset", int'(heartbeat), 0);
        chk("R1 expire after reset", int'(expire), 0);
        wait_hb(1, 90);
        chk("R1 first channel served", seq[0], 0);
        chk("R10 default width pulse", last_len[0], WRST * TDIV);
    endtask

    task automatic t_period();
        do_reset(2, 49, 8, '1);
        wait_hb(3, 0);
        chk("R2 period 2x50", hb_gap, 100);
        do_reset(3, 19, 8, '1);
        wait_hb(3, 0);
        chk("R2 period 3x20", hb_gap, 60);
        do_reset(0, 59, 8, '1);
        wait_hb(3, 0);
        chk("R2 prescale zero as one", hb_gap, 60);
    endtask

    task automatic t_rotation();
        do_reset(2, 49, 3, '1);
        wait_hb(7, 60);
        for (int i = 0; i < 6; i++) chk("R5 rotation of three", seq[i], i % 3);
        do_reset(2, 49, 0, '1);
        wait_hb(9, 60);
        chk("R5 slot count zero last", seq[7], 7);
        chk("R5 slot count zero wrap", seq[8], 0);
    endtask

    task automatic t_width();
        do_reset(2, 49, 4, '1);
        wr_width(0, 30);
        wr_width(1, 3);
        wr_width(2, 200);
        wr_width(3, 16'h0100);
        wait_hb(4, 90);
        chk("R6 written width", last_len[0], 30 * TDIV);
        chk("R7 clamp low", last_len[1], WMIN * TDIV);
        chk("R7 clamp high", last_len[2], WMAX * TDIV);
        chk("R7 clamp high byte", last_len[3], WMAX * TDIV);
        chk("R4 one expiry per pulse", exp_cnt, 4);
        chk("R4 expiry with fall", fall_bad, 0);
        chk("R4 lines low at expiry", exp_bad, 0);
    endtask

    task automatic t_atomic();
        do_reset(2, 49, 1, '1);
        wr_byte(0, 1'b0, 12);
        wait_hb(2, 90);
        chk("R6 low byte alone ignored", last_len[0], WRST * TDIV);
        wr_byte(0, 1'b1, 0);
        wait_hb(4, 90);
        chk("R6 commit on high byte", last_len[0], 12 * TDIV);
    endtask

    task automatic t_disable();
        do_reset(2, 49, 3, 8'b1111_1101);
        wait_hb(6, 90);
        chk("R8 disabled no pulse", pulse_cnt[1], 0);
        chk("R8 ch0 pulses", pulse_cnt[0], 2);
        chk("R8 ch2 pulses", pulse_cnt[2], 2);
        chk("R8 no expiry for disabled", exp_cnt, 4);
        chk("R8 slot kept", seq_cyc[1] - seq_cyc[0], 200);
    endtask

    task automatic t_trunc();
        do_reset(1, 29, 2, '1);
        wait_hb(4, 20);
        chk("R9 truncated length", last_len[0], 30);
        chk("R9 next slot starts", seq[1], 1);
        chk("R9 no overlap", multi_hot, 0);
        chk("R9 no expiry when cut", exp_cnt, 0);
    endtask

    initial begin
        t_reset();
        t_period();
        t_rotation();
        t_width();
        t_atomic();
        t_disable();
        t_trunc();
        chk("R9 one hot overall", multi_hot, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule